// File: doc/BRIEF.md
# Serial Chain Length Discovery Sequencer

This block finds how many devices are wired in series on a shared serial bus. Each device in the series delays the data stream by one 5-byte command frame. The block opens one select window. It sends a read of register 0x73, which changes no device state, and addresses it to a slot past the deepest chain it supports. It then sends enough zero bytes for that command to travel through every possible device and come back. While the window is open, the block watches the bytes coming back for an exact copy of the command. The frame-aligned position where the copy appears gives the device count.

The block connects to a byte-level exchange port, such as an existing serial shifter. For every byte the block offers, the port returns one received byte. The receive path of that port holds one frame of staging, so a chain of n devices returns the command at byte offset 5*(n+1). The result goes into a length register that the transaction logic reads.

Discovery runs in two cases: when it is requested directly, or automatically before the first access that targets a nonzero chain position while the length is still unknown. A length the user has programmed is compared with the discovered one, and a disagreement raises a flag.

Top module: `chain_len_detect`

## Requirements
- R1: One run holds `spi_cs_o` high for exactly 5*(MAX_DEV+2) byte exchanges, with one `spi_tx_valid_o` pulse per exchange. The byte values are 0x73, 0x00, 0x00, 0x00, 0x00 and then 0x00 for every remaining byte.
- R2: A received 5-byte frame counts as a match only when all five bytes equal the probe bytes exactly. The frame must start at byte offset 5*(c+1) with 1 <= c <= MAX_DEV, and it yields length c. A copy at offset 5 is not a candidate.
- R3: Candidate offsets are taken in increasing order, and only the first match counts. Later frames do not change it.
- R4: When no candidate frame matches, the stored length becomes 0 and `len_valid_o` becomes 0.
- R5: A one-cycle `done_o` pulse follows the end of every run. In that same cycle `len_o` and `len_valid_o` show the new result, and `len_valid_o` is set only on a match. After reset, the length is 0, valid is 0 and the mismatch flag is 0.
- R6: After a successful run, `mismatch_o` is 1 when `user_len_set_i` is high and `user_len_i` differs from the detected length. Otherwise it is 0, and a failed run also clears it. The detected value is the one stored.
- R7: An access request (`acc_req_i` high) with a nonzero `acc_pos_i` starts a run when no valid length is held and no automatic run has been made since reset. `acc_go_o` stays low until that run has finished.
- R8: `acc_go_o` is given with no bus traffic when the request targets position 0 or a valid length is already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a discovery run while idle |
| acc_req_i | input | 1 | An access is waiting (held high) |
| acc_pos_i | input | CNT_W | Chain position of the waiting access |
| user_len_set_i | input | 1 | A user length has been programmed |
| user_len_i | input | CNT_W | User-programmed length |
| spi_cs_o | output | 1 | Select window of the probe frame |
| spi_tx_valid_o | output | 1 | Byte offered to the exchange port |
| spi_tx_byte_o | output | 8 | Byte to transmit |
| spi_rx_valid_i | input | 1 | Received byte present |
| spi_rx_byte_i | input | 8 | Received byte |
| acc_go_o | output | 1 | The waiting access may proceed |
| done_o | output | 1 | One-cycle end-of-run pulse |
| len_o | output | CNT_W | Stored chain length |
| len_valid_o | output | 1 | Stored length came from a match |
| mismatch_o | output | 1 | User length disagrees with detected length |

## Verification
The assertions assume that the exchange port returns exactly one received byte for each offered byte, and only after the offer. They also assume that `start_i` and `acc_req_i` act only while the sequencer is idle. The bench's port model keeps to this: it answers every transmit pulse with a single receive pulse one cycle later and never answers unprompted. The scenarios wait for `done_o` or `acc_go_o` before they change a request. The chain model returns preloaded filler bytes that can never form the probe pattern, except in frames the tests plant on purpose.

// File: rtl/chain_len_pkg.sv
package chain_len_pkg;

    localparam logic [7:0] PROBE_CMD   = 8'h73;
    localparam int         FRAME_BYTES = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } byte_beat_t;

    // Byte of the probe frame: the read command first, zeros after it.
    function automatic logic [7:0] probe_byte(input logic first);
        return first ? PROBE_CMD : 8'h00;
    endfunction

endpackage

// File: rtl/probe_src.sv
module probe_src
    import chain_len_pkg::*;
#(
    parameter int MAX_DEV = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       advance,
    output logic [7:0] tx_byte,
    output logic       last
);
    localparam int TOTAL = FRAME_BYTES * (MAX_DEV + 2);
    localparam int IDX_W = $clog2(TOTAL);

    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx <= '0;
        end else if (advance) begin
            idx <= idx + IDX_W'(1);
        end
    end

    assign tx_byte = probe_byte(idx == '0);
    assign last    = (idx == IDX_W'(TOTAL - 1));

endmodule

// File: rtl/frame_match.sv
module frame_match
    import chain_len_pkg::*;
#(
    parameter int MAX_DEV = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  byte_beat_t       beat,
    output logic             hit,
    output logic [$clog2(MAX_DEV+1)-1:0] count
);
    localparam int CNT_W = $clog2(MAX_DEV + 1);
    localparam int FRM_W = $clog2(MAX_DEV + 3);

    logic [2:0]       byte_pos;
    logic [FRM_W-1:0] frame;
    logic             ok;
    logic             ok_next;

    assign ok_next = ((byte_pos == 3'd0) ? 1'b1 : ok) &&
                     (beat.data == probe_byte(byte_pos == 3'd0));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            byte_pos <= '0;
            frame    <= '0;
            ok       <= 1'b0;
            hit      <= 1'b0;
            count    <= '0;
        end else if (beat.valid) begin
            ok <= ok_next;
            if (byte_pos == 3'(FRAME_BYTES - 1)) begin
                byte_pos <= '0;
                frame    <= frame + FRM_W'(1);
                // frame 0 is the command itself, frame 1 the staging slot
                if (ok_next && !hit && frame >= FRM_W'(2)) begin
                    hit   <= 1'b1;
                    count <= CNT_W'(frame - FRM_W'(1));
                end
            end else begin
                byte_pos <= byte_pos + 3'd1;
            end
        end
    end

    // R3: the first match is kept for the rest of the run
    assert_hit_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (hit && !clear) |=> hit);
    assert_count_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        (hit && !clear) |=> $stable(count));

endmodule

// File: rtl/len_store.sv
module len_store #(
    parameter int MAX_DEV = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         commit,
    input  logic                         hit,
    input  logic [$clog2(MAX_DEV+1)-1:0] count,
    input  logic                         user_set,
    input  logic [$clog2(MAX_DEV+1)-1:0] user_len,
    output logic [$clog2(MAX_DEV+1)-1:0] len,
    output logic                         valid,
    output logic                         mismatch,
    output logic                         done
);
    localparam int CNT_W = $clog2(MAX_DEV + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            len      <= '0;
            valid    <= 1'b0;
            mismatch <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= commit;
            if (commit) begin
                if (hit) begin
                    len      <= count;
                    valid    <= 1'b1;
                    mismatch <= user_set && (user_len != count);
                end else begin
                    len      <= '0;
                    valid    <= 1'b0;
                    mismatch <= 1'b0;
                end
            end
        end
    end

    assert_valid_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        valid |-> (len != '0));
    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_len_range_R2: assert property (@(posedge clk) disable iff (rst)
        len <= CNT_W'(MAX_DEV));

endmodule

// File: rtl/chain_len_detect.sv
module chain_len_detect
    import chain_len_pkg::*;
#(
    parameter int MAX_DEV = 8,
    localparam int CNT_W  = $clog2(MAX_DEV + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             acc_req_i,
    input  logic [CNT_W-1:0] acc_pos_i,
    input  logic             user_len_set_i,
    input  logic [CNT_W-1:0] user_len_i,
    output logic             spi_cs_o,
    output logic             spi_tx_valid_o,
    output logic [7:0]       spi_tx_byte_o,
    input  logic             spi_rx_valid_i,
    input  logic [7:0]       spi_rx_byte_i,
    output logic             acc_go_o,
    output logic             done_o,
    output logic [CNT_W-1:0] len_o,
    output logic             len_valid_o,
    output logic             mismatch_o
);
    seq_state_e       state;
    logic             attempted;
    logic             need_run;
    logic             launch;
    logic             consume;
    logic             last_byte;
    logic             hit;
    logic [CNT_W-1:0] count;
    byte_beat_t       beat;

    assign need_run = (acc_pos_i != '0) && !len_valid_o && !attempted;
    assign launch   = (state == ST_IDLE) && (start_i || (acc_req_i && need_run));
    assign consume  = (state == ST_WAIT) && spi_rx_valid_i;
    assign beat     = '{valid: consume, data: spi_rx_byte_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            attempted <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (launch) state <= ST_SEND;
                ST_SEND: state <= ST_WAIT;
                ST_WAIT: if (consume) state <= last_byte ? ST_FIN : ST_SEND;
                ST_FIN: begin
                    state     <= ST_IDLE;
                    attempted <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign spi_cs_o       = (state == ST_SEND) || (state == ST_WAIT);
    assign spi_tx_valid_o = (state == ST_SEND);
    assign acc_go_o       = acc_req_i && (state == ST_IDLE) && !need_run;

    probe_src #(.MAX_DEV(MAX_DEV)) u_src (
        .clk     (clk),
        .rst     (rst),
        .clear   (launch),
        .advance (consume),
        .tx_byte (spi_tx_byte_o),
        .last    (last_byte)
    );

    frame_match #(.MAX_DEV(MAX_DEV)) u_match (
        .clk   (clk),
        .rst   (rst),
        .clear (launch),
        .beat  (beat),
        .hit   (hit),
        .count (count)
    );

    len_store #(.MAX_DEV(MAX_DEV)) u_store (
        .clk      (clk),
        .rst      (rst),
        .commit   (state == ST_FIN),
        .hit      (hit),
        .count    (count),
        .user_set (user_len_set_i),
        .user_len (user_len_i),
        .len      (len_o),
        .valid    (len_valid_o),
        .mismatch (mismatch_o),
        .done     (done_o)
    );

    // R1: every window opens with the read command byte
    assert_first_byte_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_o) |-> (spi_tx_byte_o == PROBE_CMD));
    // R5: closing the window is followed by the done pulse
    assert_done_after_window_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_o) |=> done_o);

endmodule

// File: tb/chain_len_detect_tb.sv
module chain_len_detect_tb;
    localparam int MAX_DEV = 8;
    localparam int CNT_W   = $clog2(MAX_DEV + 1);
    localparam int TOTAL   = 5 * (MAX_DEV + 2);

    logic clk = 1'b0;
    logic rst;
    logic start_i, acc_req_i, user_len_set_i;
    logic [CNT_W-1:0] acc_pos_i, user_len_i;
    logic spi_cs_o, spi_tx_valid_o, spi_rx_valid_i;
    logic [7:0] spi_tx_byte_o, spi_rx_byte_i;
    logic acc_go_o, done_o, len_valid_o, mismatch_o;
    logic [CNT_W-1:0] len_o;

    int errors = 0;
    int checks = 0;

    logic [7:0] sr [0:127];
    int stages;
    logic [7:0] tx_log [0:127];
    int tx_count;

    always #4 clk = ~clk;

    chain_len_detect #(.MAX_DEV(MAX_DEV)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .acc_req_i(acc_req_i),
        .acc_pos_i(acc_pos_i), .user_len_set_i(user_len_set_i),
        .user_len_i(user_len_i), .spi_cs_o(spi_cs_o),
        .spi_tx_valid_o(spi_tx_valid_o), .spi_tx_byte_o(spi_tx_byte_o),
        .spi_rx_valid_i(spi_rx_valid_i), .spi_rx_byte_i(spi_rx_byte_i),
        .acc_go_o(acc_go_o), .done_o(done_o), .len_o(len_o),
        .len_valid_o(len_valid_o), .mismatch_o(mismatch_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Port model: n devices plus one frame of return staging.
    initial begin
        spi_rx_valid_i = 1'b0;
        spi_rx_byte_i  = 8'h00;
        forever begin
            @(negedge clk);
            spi_rx_valid_i = 1'b0;
            if (spi_tx_valid_o) begin
                logic [7:0] b;
                b = spi_tx_byte_o;
                if (tx_count < 128) tx_log[tx_count] = b;
                tx_count++;
                @(negedge clk);
                spi_rx_byte_i = sr[stages-1];
                for (int k = stages - 1; k > 0; k--) sr[k] = sr[k-1];
                sr[0] = b;
                spi_rx_valid_i = 1'b1;
            end
        end
    end

    task automatic set_chain(input int n);
        stages = 5 * (n + 1);
        for (int k = 0; k < 128; k++) sr[k] = 8'hA0 ^ 8'(k);
        tx_count = 0;
    endtask

    // Place a frame in the returned stream at frame index f; tail is its last byte.
    task automatic plant(input int f, input logic [7:0] tail);
        sr[stages-1-5*f] = 8'h73;
        for (int b = 1; b < 4; b++) sr[stages-1-5*f-b] = 8'h00;
        sr[stages-1-5*f-4] = tail;
    endtask

    task automatic do_reset;
        rst = 1'b1; start_i = 0; acc_req_i = 0; acc_pos_i = '0;
        user_len_set_i = 0; user_len_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_detect;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int c = 0; c < 2000; c++) begin
            #1;
            if (done_o) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        do_reset();
        #1;
        check(len_o == 0 && !len_valid_o && !mismatch_o && !done_o && !spi_cs_o,
              "R5 reset state", int'(len_o), 0);
    endtask

    task automatic t_probe_and_basic;
        set_chain(3);
        run_detect();
        check(done_o == 1'b1, "R5 done pulse", int'(done_o), 1);
        check(len_o == 3 && len_valid_o, "R2 length n=3", int'(len_o), 3);
        check(tx_count == TOTAL, "R1 byte count", tx_count, TOTAL);
        begin
            int bad = 0;
            for (int i = 0; i < TOTAL; i++)
                if (tx_log[i] != ((i == 0) ? 8'h73 : 8'h00)) bad++;
            check(bad == 0, "R1 probe bytes", bad, 0);
        end
        @(negedge clk); #1;
        check(!done_o, "R5 done single cycle", int'(done_o), 0);
    endtask

    task automatic t_lengths;
        set_chain(1); run_detect();
        check(len_o == 1 && len_valid_o, "R2 length n=1", int'(len_o), 1);
        set_chain(MAX_DEV); run_detect();
        check(len_o == MAX_DEV && len_valid_o, "R2 length max", int'(len_o), MAX_DEV);
    endtask

    task automatic t_no_match;
        set_chain(MAX_DEV + 1); run_detect();
        check(len_o == 0 && !len_valid_o, "R4 chain beyond depth", int'(len_valid_o), 0);
        set_chain(0); run_detect();
        check(len_o == 0 && !len_valid_o, "R4 offset 5 excluded", int'(len_o), 0);
    endtask

    task automatic t_ordering;
        set_chain(5); plant(2, 8'h00); run_detect();
        check(len_o == 1, "R3 earliest match wins", int'(len_o), 1);
        set_chain(3); plant(1, 8'h00); run_detect();
        check(len_o == 3, "R2 frame at offset 5 ignored", int'(len_o), 3);
        set_chain(4); plant(2, 8'h01); run_detect();
        check(len_o == 4, "R2 partial frame rejected", int'(len_o), 4);
    endtask

    task automatic t_mismatch;
        user_len_set_i = 1; user_len_i = 2;
        set_chain(3); run_detect();
        check(mismatch_o && len_o == 3, "R6 mismatch raised", int'(mismatch_o), 1);
        user_len_i = 3;
        set_chain(3); run_detect();
        check(!mismatch_o, "R6 equal lengths", int'(mismatch_o), 0);
        user_len_i = 2;
        set_chain(MAX_DEV + 1); run_detect();
        check(!mismatch_o, "R6 cleared on failure", int'(mismatch_o), 0);
        user_len_set_i = 0;
    endtask

    task automatic t_auto;
        bit saw_cs;
        bit got;
        do_reset();
        set_chain(2);
        saw_cs = 0; got = 0;
        acc_pos_i = 2; acc_req_i = 1;
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk); #1;
            if (spi_cs_o) saw_cs = 1;
            if (acc_go_o) begin got = 1; break; end
        end
        check(got && saw_cs, "R7 run before grant", int'(saw_cs), 1);
        check(len_o == 2 && len_valid_o, "R7 auto length", int'(len_o), 2);
        acc_req_i = 0;
        @(negedge clk);
        acc_pos_i = 3; acc_req_i = 1; #1;
        check(acc_go_o && !spi_cs_o, "R8 valid length grants", int'(acc_go_o), 1);
        acc_req_i = 0;
        do_reset();
        set_chain(2);
        acc_pos_i = 0; acc_req_i = 1; #1;
        check(acc_go_o, "R8 position 0 grants", int'(acc_go_o), 1);
        saw_cs = 0;
        repeat (3) begin @(negedge clk); #1; if (spi_cs_o) saw_cs = 1; end
        check(!saw_cs && tx_count == 0, "R8 no traffic", tx_count, 0);
        acc_req_i = 0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        set_chain(1);
        t_reset();
        t_probe_and_basic();
        t_lengths();
        t_no_match();
        t_ordering();
        t_mismatch();
        t_auto();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule